// File: doc/BRIEF.md
# SPI NAND Block Erase Sequencer

This block runs a complete block erase on a serial NAND flash from the host side. A single-cycle start request, together with a row address and a density select, launches three kinds of serial transaction back to back. The first is a write-enable command. The second is the erase command with a 24-bit address that is padded for the selected density. The rest are repeated status-register reads, which continue until the device reports that it is no longer busy. The block then pulses a done strobe and presents the last status byte. Flags beside the strobe report whether the poll budget ran out and whether the write-enable latch was still set when the device finished.

The serial clock idles low while chip select is high. Data leaves the host on the falling edge and is sampled on the rising edge, so a device that uses either the idle-low or the idle-high clock convention accepts the traffic. Between any two transactions, chip select stays high for a programmable minimum number of system clocks. The serial clock is the system clock divided by a parameter.

Top module: `nes_erase_seq`

## Requirements
- R1: After reset, and whenever no erase is running, chip select is high, the serial clock is low, and busy and done are low.
- R2: Each erase begins with a transaction that carries only the 8-bit write-enable opcode 06h in its own chip-select low period.
- R3: The erase transaction sends opcode D8h and then 24 address bits, MSB first, for exactly 32 serial clocks. Chip select rises right after the last bit.
- R4: With the density select high, the address is 7 zero bits followed by the 17-bit row address.
- R5: With the density select low, the address is 8 zero bits followed by the low 16 bits of the row address. Row bit 16 is dropped.
- R6: A status poll sends opcode 0Fh and feature address C0h, then reads 8 bits MSB first on rising serial clock edges, for 24 clocks in total.
- R7: Polls repeat while status bit 0 (operation in progress) reads 1. When it reads 0, done pulses for exactly one cycle, busy falls, and the status output holds that byte.
- R8: Chip select stays high for at least GAP_CYCLES system clocks between any two transactions.
- R9: If MAX_POLLS polls all return bit 0 set, the sequence stops with done and timeout asserted together, and the status output holds the last byte.
- R10: If the device completes while status bit 1 (write-enable latch) is still 1, the error flag is asserted with done.
- R11: A start request that arrives while an erase is running is ignored and does not disturb the running sequence.
- R12: The serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin an erase |
| row_addr_i | input | ROW_W | Row (block/page) address, sampled with start |
| dens_wide_i | input | 1 | 1: 17-bit row with 7 pad bits; 0: 16-bit row with 8 pad bits |
| busy_o | output | 1 | High from the accepted start until done |
| done_o | output | 1 | One-cycle completion strobe |
| status_o | output | 8 | Last status byte read from the device |
| timeout_o | output | 1 | Poll budget exhausted; valid with done |
| wel_stuck_o | output | 1 | Device finished with write-enable latch set; valid with done |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_sck_o | output | 1 | Serial clock |
| spi_si_o | output | 1 | Serial data to the device |
| spi_so_i | input | 1 | Serial data from the device |

## Verification
The bench builds the block with a clock divider of 2, a chip-select gap of 3 cycles and a poll budget of 5. With these values every frame's bit timing can be followed in a few hundred cycles, and a poll timeout is reached after only five busy reads. A behavioural device model answers the status polls with a configurable number of busy replies. This lets one run cover a device that finishes on the first poll, one that needs several polls, one that never finishes before the budget runs out, and one that leaves its write-enable latch set. Both density settings are exercised, including a row whose top bit must be dropped.

// File: rtl/nes_pkg.sv
package nes_pkg;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_ERASE  = 8'hD8;
  localparam logic [7:0] OPC_GETF   = 8'h0F;
  localparam logic [7:0] FADDR_STAT = 8'hC0;
  localparam int FRAME_W = 32;
  localparam int NBITS_W = 6;
  localparam int ADDR_W  = 24;
  localparam int STAT_W  = 8;
  localparam int OIP_BIT = 0;
  localparam int WEL_BIT = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_GAP} seq_state_t;
  typedef enum logic [1:0] {OP_WREN, OP_ERASE, OP_POLL} seq_op_t;
endpackage

// File: rtl/nes_addr_fmt.sv
module nes_addr_fmt #(
  parameter int ROW_W  = 17,
  parameter int ADDR_W = 24
) (
  input  logic [ROW_W-1:0]  row_i,
  input  logic              wide_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PAD_WIDE   = ADDR_W - ROW_W;
  localparam int NARROW_W   = ROW_W - 1;
  localparam int PAD_NARROW = ADDR_W - NARROW_W;

  always_comb begin
    if (wide_i) addr_o = {{PAD_WIDE{1'b0}}, row_i};
    else        addr_o = {{PAD_NARROW{1'b0}}, row_i[NARROW_W-1:0]};
  end
endmodule

// File: rtl/nes_spi_engine.sv
module nes_spi_engine #(
  parameter int CLK_DIV = 4,
  parameter int FRAME_W = 32,
  parameter int NBITS_W = 6,
  parameter int RX_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [NBITS_W-1:0] nbits_i,
  output logic               done_o,
  output logic [RX_W-1:0]    rx_o,
  output logic               cs_n_o,
  output logic               sck_o,
  output logic               si_o,
  input  logic               so_i
);
  localparam int DIV_W = (CLK_DIV < 2) ? 1 : $clog2(CLK_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic               active;
  logic [DIV_W-1:0]   div_cnt;
  logic [NBITS_W-1:0] bits_left;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      div_cnt   <= '0;
      bits_left <= '0;
      shreg     <= '0;
      done_o    <= 1'b0;
      rx_o      <= '0;
      cs_n_o    <= 1'b1;
      sck_o     <= 1'b0;
      si_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active) begin
        if (go_i) begin
          active    <= 1'b1;
          cs_n_o    <= 1'b0;
          sck_o     <= 1'b0;
          shreg     <= frame_i;
          si_o      <= frame_i[FRAME_W-1];
          bits_left <= nbits_i;
          div_cnt   <= '0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sck_o) begin
          sck_o <= 1'b1;
          rx_o  <= {rx_o[RX_W-2:0], so_i};
        end else begin
          sck_o     <= 1'b0;
          shreg     <= {shreg[FRAME_W-2:0], 1'b0};
          si_o      <= shreg[FRAME_W-2];
          bits_left <= bits_left - 1'b1;
          if (bits_left == NBITS_W'(1)) begin
            active <= 1'b0;
            cs_n_o <= 1'b1;
            si_o   <= 1'b0;
            done_o <= 1'b1;
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nes_ctrl.sv
module nes_ctrl
  import nes_pkg::*;
#(
  parameter int GAP_CYCLES = 8,
  parameter int MAX_POLLS  = 100000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               eng_go_o,
  output logic [FRAME_W-1:0] eng_frame_o,
  output logic [NBITS_W-1:0] eng_nbits_o,
  input  logic               eng_done_i,
  input  logic [STAT_W-1:0]  eng_rx_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [STAT_W-1:0]  status_o,
  output logic               timeout_o,
  output logic               wel_stuck_o
);
  localparam int GAP_W  = $clog2(GAP_CYCLES + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(GAP_CYCLES - 1);
  localparam logic [POLL_W-1:0] POLL_MAX  = POLL_W'(MAX_POLLS);

  seq_state_t         state;
  seq_op_t            op;
  logic [ADDR_W-1:0]  addr_q;
  logic [GAP_W-1:0]   gap_cnt;
  logic [POLL_W-1:0]  poll_cnt;

  assign eng_go_o = (state == ST_ISSUE);

  always_comb begin
    case (op)
      OP_WREN: begin
        eng_frame_o = {OPC_WREN, 24'h0};
        eng_nbits_o = NBITS_W'(8);
      end
      OP_ERASE: begin
        eng_frame_o = {OPC_ERASE, addr_q};
        eng_nbits_o = NBITS_W'(32);
      end
      default: begin
        eng_frame_o = {OPC_GETF, FADDR_STAT, 16'h0};
        eng_nbits_o = NBITS_W'(24);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op          <= OP_WREN;
      addr_q      <= '0;
      gap_cnt     <= '0;
      poll_cnt    <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      status_o    <= '0;
      timeout_o   <= 1'b0;
      wel_stuck_o <= 1'b0;
    end else begin
      done_o      <= 1'b0;
      timeout_o   <= 1'b0;
      wel_stuck_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            addr_q   <= addr_i;
            op       <= OP_WREN;
            poll_cnt <= '0;
            busy_o   <= 1'b1;
            state    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          state <= ST_WAIT;
          if (op == OP_POLL) poll_cnt <= poll_cnt + 1'b1;
        end
        ST_WAIT: begin
          if (eng_done_i) begin
            gap_cnt <= '0;
            state   <= ST_GAP;
          end
        end
        default: begin
          if (gap_cnt != GAP_LAST) begin
            gap_cnt <= gap_cnt + 1'b1;
          end else begin
            case (op)
              OP_WREN: begin
                op    <= OP_ERASE;
                state <= ST_ISSUE;
              end
              OP_ERASE: begin
                op    <= OP_POLL;
                state <= ST_ISSUE;
              end
              default: begin
                if (!eng_rx_i[OIP_BIT]) begin
                  state       <= ST_IDLE;
                  busy_o      <= 1'b0;
                  done_o      <= 1'b1;
                  status_o    <= eng_rx_i;
                  wel_stuck_o <= eng_rx_i[WEL_BIT];
                end else if (poll_cnt == POLL_MAX) begin
                  state     <= ST_IDLE;
                  busy_o    <= 1'b0;
                  done_o    <= 1'b1;
                  status_o  <= eng_rx_i;
                  timeout_o <= 1'b1;
                end else begin
                  state <= ST_ISSUE;
                end
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nes_erase_seq.sv
module nes_erase_seq
  import nes_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int GAP_CYCLES = 8,
  parameter int MAX_POLLS  = 100000,
  parameter int ROW_W      = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [ROW_W-1:0] row_addr_i,
  input  logic             dens_wide_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       status_o,
  output logic             timeout_o,
  output logic             wel_stuck_o,
  output logic             spi_cs_n_o,
  output logic             spi_sck_o,
  output logic             spi_si_o,
  input  logic             spi_so_i
);
  logic [ADDR_W-1:0]  addr_fmt;
  logic               eng_go;
  logic [FRAME_W-1:0] eng_frame;
  logic [NBITS_W-1:0] eng_nbits;
  logic               eng_done;
  logic [STAT_W-1:0]  eng_rx;

  nes_addr_fmt #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_fmt (
    .row_i  (row_addr_i),
    .wide_i (dens_wide_i),
    .addr_o (addr_fmt)
  );

  nes_ctrl #(.GAP_CYCLES(GAP_CYCLES), .MAX_POLLS(MAX_POLLS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .addr_i      (addr_fmt),
    .eng_go_o    (eng_go),
    .eng_frame_o (eng_frame),
    .eng_nbits_o (eng_nbits),
    .eng_done_i  (eng_done),
    .eng_rx_i    (eng_rx),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_o),
    .timeout_o   (timeout_o),
    .wel_stuck_o (wel_stuck_o)
  );

  nes_spi_engine #(.CLK_DIV(CLK_DIV), .FRAME_W(FRAME_W), .NBITS_W(NBITS_W), .RX_W(STAT_W)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .go_i    (eng_go),
    .frame_i (eng_frame),
    .nbits_i (eng_nbits),
    .done_o  (eng_done),
    .rx_o    (eng_rx),
    .cs_n_o  (spi_cs_n_o),
    .sck_o   (spi_sck_o),
    .si_o    (spi_si_o),
    .so_i    (spi_so_i)
  );
endmodule

// File: rtl/nes_erase_seq_chk.sv
module nes_erase_seq_chk #(
  parameter int GAP_CYCLES = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] status_o,
  input logic       timeout_o,
  input logic       wel_stuck_o,
  input logic       spi_cs_n_o,
  input logic       spi_sck_o
);
  logic [15:0] hi_cnt;
  logic        seen_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      seen_low <= 1'b0;
    end else begin
      if (spi_cs_n_o) begin
        if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt   <= '0;
        seen_low <= 1'b1;
      end
    end
  end

  // R1
  a_r1_bus_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (spi_cs_n_o && !spi_sck_o));
  // R12
  a_r12_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n_o |-> !spi_sck_o);
  // R7
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R7
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R9
  a_r9_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (done_o && status_o[0]));
  // R10
  a_r10_wel_flag_with_done: assert property (@(posedge clk) disable iff (rst)
    wel_stuck_o |-> (done_o && !timeout_o && status_o[1] && !status_o[0]));
  // R8
  a_r8_min_cs_high: assert property (@(posedge clk) disable iff (rst)
    (seen_low && spi_cs_n_o && busy_o) |=> (spi_cs_n_o || hi_cnt >= 16'(GAP_CYCLES)));
endmodule

bind nes_erase_seq nes_erase_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .status_o    (status_o),
  .timeout_o   (timeout_o),
  .wel_stuck_o (wel_stuck_o),
  .spi_cs_n_o  (spi_cs_n_o),
  .spi_sck_o   (spi_sck_o)
);

// File: tb/test_nes_erase_seq.sv
`timescale 1ns/1ps
module test_nes_erase_seq;
  localparam int CLK_DIV    = 2;
  localparam int GAP_CYCLES = 3;
  localparam int MAX_POLLS  = 5;
  localparam int ROW_W      = 17;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [ROW_W-1:0] row = '0;
  logic             wide = 1'b0;
  logic             busy, done, tmo, wstk, cs_n, sck, si;
  logic             so = 1'b0;
  logic [7:0]       stat;

  always #10 clk = ~clk;

  nes_erase_seq #(.CLK_DIV(CLK_DIV), .GAP_CYCLES(GAP_CYCLES), .MAX_POLLS(MAX_POLLS), .ROW_W(ROW_W)) i_nes_erase_seq (
    .clk(clk), .rst(rst), .start_i(start), .row_addr_i(row), .dens_wide_i(wide),
    .busy_o(busy), .done_o(done), .status_o(stat), .timeout_o(tmo), .wel_stuck_o(wstk),
    .spi_cs_n_o(cs_n), .spi_sck_o(sck), .spi_si_o(si), .spi_so_i(so)
  );

  int n_chk = 0;
  int n_fail = 0;
  int done_seen = 0;

  // scoreboard queues
  int          exp_bits_q[$];
  logic [31:0] exp_val_q[$];
  string       exp_req_q[$];
  logic [9:0]  res_q[$];   // {status, timeout, wel_stuck}

  // device model
  logic [31:0] cap = '0;
  int          ncap = 0;
  int          busy_left = 0;
  int          cfg_busy = 0;
  bit          cfg_stick = 0;
  bit          wel = 0;
  logic [7:0]  stat_lat = '0;
  realtime     t_rise = 0;
  bit          have_rise = 0;

  always @(negedge cs_n) begin
    if (have_rise) begin
      n_chk++;
      if ((($realtime - t_rise) / 20.0) < GAP_CYCLES) begin
        n_fail++;
        $display("FAIL R8: cs high %0t ns, expected >= %0d cycles", $realtime - t_rise, GAP_CYCLES);
      end
    end
    cap  = '0;
    ncap = 0;
  end

  always @(posedge sck) if (!cs_n) begin
    cap = {cap[30:0], si};
    ncap++;
  end

  always @(negedge sck) if (!cs_n && ncap >= 16 && ncap < 24) begin
    if (ncap == 16) stat_lat = {6'b0, wel, busy_left != 0};
    so = stat_lat[23-ncap];
  end

  always @(posedge cs_n) if (ncap > 0) begin
    t_rise = $realtime;
    have_rise = 1;
    if (ncap == 8 && cap[7:0] == 8'h06) wel = 1;
    else if (ncap == 32 && cap[31:24] == 8'hD8) begin
      busy_left = cfg_busy;
      if (cfg_busy == 0 && !cfg_stick) wel = 0;
    end else if (ncap == 24 && cap[23:8] == 16'h0FC0) begin
      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0 && !cfg_stick) wel = 0;
      end
    end
    n_chk++;
    if (exp_bits_q.size() == 0) begin
      n_fail++;
      $display("FAIL R7: unexpected transaction bits=%0d val=%h, expected none", ncap, cap);
    end else begin
      int eb;
      logic [31:0] ev;
      string er;
      eb = exp_bits_q.pop_front();
      ev = exp_val_q.pop_front();
      er = exp_req_q.pop_front();
      if (eb != ncap || ev != cap) begin
        n_fail++;
        $display("FAIL %s: transaction bits=%0d val=%h, expected bits=%0d val=%h", er, ncap, cap, eb, ev);
      end
    end
  end

  // result monitor
  always @(negedge clk) if (!rst && done) begin
    done_seen++;
    n_chk++;
    if (res_q.size() == 0) begin
      n_fail++;
      $display("FAIL R7: unexpected done, expected none");
    end else begin
      logic [9:0] e;
      e = res_q.pop_front();
      if ({stat, tmo, wstk} != e) begin
        n_fail++;
        $display("FAIL R7/R9/R10: status=%h to=%b ws=%b, expected status=%h to=%b ws=%b",
                 stat, tmo, wstk, e[9:2], e[1], e[0]);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_erase(input logic [16:0] r, input bit w, input int nbusy, input bit stick,
                           input int polls, input logic [7:0] est, input bit eto, input bit ews,
                           input bit poke);
    logic [23:0] a;
    int d0;
    cfg_busy  = nbusy;
    cfg_stick = stick;
    a = w ? {7'b0, r} : {8'b0, r[15:0]};
    exp_bits_q.push_back(8);  exp_val_q.push_back(32'h06);              exp_req_q.push_back("R2");
    exp_bits_q.push_back(32); exp_val_q.push_back({8'hD8, a});          exp_req_q.push_back(w ? "R3/R4" : "R3/R5");
    for (int i = 0; i < polls; i++) begin
      exp_bits_q.push_back(24); exp_val_q.push_back(32'h000FC000);     exp_req_q.push_back("R6");
    end
    res_q.push_back({est, eto, ews});
    d0 = done_seen;
    @(negedge clk); start = 1; row = r; wide = w;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1; row = ~r; wide = ~w;
      @(negedge clk); start = 0;
      check(busy == 1'b1, "R11 busy kept", busy, 1);
    end
    while (done_seen == d0) @(negedge clk);
    check(busy == 1'b0, "R7 busy after done", busy, 0);
    check(exp_bits_q.size() == 0, "R7 missing transactions", exp_bits_q.size(), 0);
    repeat (10) @(negedge clk);
    check(cs_n == 1'b1 && sck == 1'b0, "R1 bus idle", {cs_n, sck}, 2);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(cs_n == 1 && sck == 0 && busy == 0 && done == 0, "R1 reset",
          {cs_n, sck, busy, done}, 4'b1000);
    // R4 wide density, several busy polls (R7)
    run_erase(17'h1ABCD, 1, 2, 0, 3, 8'h00, 0, 0, 0);
    // R5 narrow density drops row bit 16, ready on first poll
    run_erase(17'h1F00F, 0, 0, 0, 1, 8'h00, 0, 0, 0);
    // R9 timeout after MAX_POLLS busy polls
    run_erase(17'h0A5A5, 1, 10, 0, MAX_POLLS, 8'h03, 1, 0, 0);
    // R10 write-enable latch left set; R6 bit order (02h vs 01h)
    run_erase(17'h12345, 1, 1, 1, 2, 8'h02, 0, 1, 0);
    // R11 start ignored during a running erase
    run_erase(17'h00001, 1, 3, 0, 4, 8'h00, 0, 0, 1);
    // R5 narrow density, full 16-bit row
    run_erase(17'h0FFFF, 0, 1, 0, 2, 8'h00, 0, 0, 0);
    repeat (20) @(negedge clk);
    check(exp_bits_q.size() == 0 && res_q.size() == 0, "R7 queues drained",
          exp_bits_q.size() + res_q.size(), 0);
    summary();
  end
endmodule